// File: doc/BRIEF.md
# Writeback Slot Reservation Shift Register

This block sits beside the decode stage of an in-order pipeline whose single writeback port is shared by execution units of different fixed latencies. When an instruction is in decode, the block works out in which future cycle that instruction's result will reach writeback. It then looks that cycle up in a vector of future writeback slots. If the slot is free, the instruction is accepted and the slot is booked. If the slot is taken, issue is stalled for this cycle. The vector moves one position toward the present on every clock, whether or not decode stalls. A stalled instruction is therefore retried on the next cycle against a slot one cycle later. Conflicts on the writeback port are settled before execution begins, so the writeback stage needs no arbiter.

Each class has a fixed latency: integer 0, floating-point add 3, floating-point multiply 6, divide 25. A fixed gap of `WB_GAP` cycles (default 3) covers the stages between decode and writeback. An instruction accepted in cycle t therefore writes back in cycle t + latency + WB_GAP. The divide unit is not pipelined. A small state machine (states `DG_IDLE` and `DG_BUSY`) blocks a second divide until the first has occupied the unit for its full latency. A second state machine (states `ISS_IDLE` and `ISS_WAIT`) follows whether decode is holding a stalled instruction. Its transitions are: `ISS_IDLE`→`ISS_WAIT` on a stall, `ISS_WAIT`→`ISS_WAIT` on a further stall, `ISS_WAIT`→`ISS_IDLE` on accept, and `ISS_IDLE`→`ISS_IDLE` otherwise. The divide guard moves `DG_IDLE`→`DG_BUSY` when a divide is accepted. It stays in `DG_BUSY` while its count is above one, and returns `DG_BUSY`→`DG_IDLE` when the count reaches one.

Top module: `wb_slot_reserve`

## Requirements
- R1: After reset no slot is booked and the divider is free, so the first valid instruction of any class is accepted in its decode cycle without a stall.
- R2: While `dec_valid` is low, both `issue_stall` and `issue_accept` are low and nothing is booked, whatever `dec_class` shows.
- R3: Class codes are 0 integer, 1 floating-point add, 2 floating-point multiply and 3 divide. An instruction accepted in cycle t books the writeback slot of cycle t + latency + 3, with latencies 0, 3, 6 and 25.
- R4: In any cycle, `issue_stall` and `issue_accept` are never both high. With `dec_valid` high, exactly one of them is high. Accept happens only when the target slot is free and, for a divide, the divider is free.
- R5: The slot vector advances every clock, including stall cycles. A stalled instruction is checked again in the next cycle against a target one cycle later.
- R6: A multiply decoded at t followed by an add decoded at t+3 both aim at the slot of t+9. The add stalls exactly one cycle and is accepted at t+4.
- R7: Completion may be out of order. Two integer instructions decoded at t+1 and t+2 after a multiply at t are accepted without a stall.
- R8: A divide decoded while a previous divide was accepted fewer than 25 cycles earlier stalls. A divide offered every cycle after one accepted at t is accepted at t+25, after 24 stall cycles.
- R9: A busy divider does not block non-divide classes whose writeback slot is free.
- R10: A divide books its writeback slot like any class. An integer decoded 25 cycles after a divide aims at the same slot, so it stalls exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | An instruction is present in decode this cycle |
| dec_class | input | 2 | Class of the decoding instruction (0 int, 1 fadd, 2 fmul, 3 div) |
| issue_stall | output | 1 | The decoding instruction must wait this cycle |
| issue_accept | output | 1 | The decoding instruction enters execution; its slot is booked |

## Verification
The assertions take for granted that decode keeps a stalled instruction in place: once `issue_stall` has been raised, `dec_valid` stays high and `dec_class` keeps its value until `issue_accept` is seen. The random stimulus keeps to this. It draws a new instruction or an idle cycle only after the previous one has been accepted, and otherwise presents the same class again. The directed cases drive one instruction at a time through a task that holds it until acceptance, so the hold-stable check in the issue tracker never sees a class change under a stall.

// File: rtl/wbsr_pkg.sv
package wbsr_pkg;

    // Instruction class codes seen at decode
    typedef enum logic [1:0] {
        OP_INT  = 2'd0,
        OP_FADD = 2'd1,
        OP_FMUL = 2'd2,
        OP_DIV  = 2'd3
    } op_class_e;

    // Divider occupancy guard states
    typedef enum logic {
        DG_IDLE = 1'b0,
        DG_BUSY = 1'b1
    } div_state_e;

    // Decode issue tracker states
    typedef enum logic {
        ISS_IDLE = 1'b0,
        ISS_WAIT = 1'b1
    } iss_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wbsr_target.sv
module wbsr_target
    import wbsr_pkg::*;
#(
    parameter int unsigned LAT_INT  = 0,
    parameter int unsigned LAT_FADD = 3,
    parameter int unsigned LAT_FMUL = 6,
    parameter int unsigned LAT_DIV  = 25,
    parameter int unsigned WB_GAP   = 3,
    parameter int unsigned IDX_W    = 5
) (
    input  op_class_e        op_class,
    output logic [IDX_W-1:0] slot_idx
);

    localparam logic [IDX_W-1:0] IDX_INT  = IDX_W'(LAT_INT  + WB_GAP);
    localparam logic [IDX_W-1:0] IDX_FADD = IDX_W'(LAT_FADD + WB_GAP);
    localparam logic [IDX_W-1:0] IDX_FMUL = IDX_W'(LAT_FMUL + WB_GAP);
    localparam logic [IDX_W-1:0] IDX_DIV  = IDX_W'(LAT_DIV  + WB_GAP);

    // Distance in cycles from decode to this class's writeback slot
    always_comb begin
        unique case (op_class)
            OP_INT:  slot_idx = IDX_INT;
            OP_FADD: slot_idx = IDX_FADD;
            OP_FMUL: slot_idx = IDX_FMUL;
            OP_DIV:  slot_idx = IDX_DIV;
            default: slot_idx = IDX_INT;
        endcase
    end

endmodule

// File: rtl/wbsr_slot_ring.sv
module wbsr_slot_ring #(
    parameter int unsigned DEPTH = 29,
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] probe_idx,
    input  logic             book,
    output logic             probe_busy
);

    // slot_q[i] set: writeback port is taken i cycles from now
    logic [DEPTH-1:0] slot_q;
    logic [DEPTH-1:0] slot_d;

    // Each position takes its upper neighbour; the booked slot lands one
    // position lower because the whole vector moves at the same edge.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        if (gi + 1 < DEPTH) begin : g_mid
            assign slot_d[gi] = slot_q[gi+1] ||
                                (book && (probe_idx == IDX_W'(gi + 1)));
        end else begin : g_top
            assign slot_d[gi] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign probe_busy = (probe_idx < IDX_W'(DEPTH)) ? slot_q[probe_idx] : 1'b0;

    // R5
    shift_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q[1] |=> slot_q[0]);

    // R4
    no_double_book_chk: assert property (@(posedge clk) disable iff (!rst_n)
        book |-> !probe_busy);

endmodule

// File: rtl/wbsr_div_guard.sv
module wbsr_div_guard
    import wbsr_pkg::*;
#(
    parameter int unsigned LAT_DIV = 25,
    parameter int unsigned CNT_W   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    if (LAT_DIV > 1) begin : g_guard
        localparam logic [CNT_W-1:0] HOLD_CNT = CNT_W'(LAT_DIV - 1);

        div_state_e       state_q, state_d;
        logic [CNT_W-1:0] cnt_q, cnt_d;

        // Next state and count
        always_comb begin
            state_d = state_q;
            cnt_d   = cnt_q;
            unique case (state_q)
                DG_IDLE: begin
                    if (start) begin
                        state_d = DG_BUSY;
                        cnt_d   = HOLD_CNT;
                    end
                end
                DG_BUSY: begin
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = DG_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                default: begin
                    state_d = DG_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end

        // State register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= DG_IDLE;
                cnt_q   <= '0;
            end else begin
                state_q <= state_d;
                cnt_q   <= cnt_d;
            end
        end

        // Outputs
        always_comb begin
            unique case (state_q)
                DG_IDLE: busy = 1'b0;
                DG_BUSY: busy = 1'b1;
                default: busy = 1'b0;
            endcase
        end

        // R8
        div_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start |-> (state_q == DG_IDLE));

        // R8
        div_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == DG_BUSY && cnt_q == CNT_W'(1)) |=> (state_q == DG_IDLE));

        // R8
        div_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == DG_BUSY) |-> (cnt_q != '0));
    end else begin : g_none
        assign busy = 1'b0;
    end

endmodule

// File: rtl/wb_slot_reserve.sv
module wb_slot_reserve
    import wbsr_pkg::*;
#(
    parameter int unsigned LAT_INT  = 0,
    parameter int unsigned LAT_FADD = 3,
    parameter int unsigned LAT_FMUL = 6,
    parameter int unsigned LAT_DIV  = 25,
    parameter int unsigned WB_GAP   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_valid,
    input  logic [1:0] dec_class,
    output logic       issue_stall,
    output logic       issue_accept
);

    localparam int unsigned MAX_LAT = max2(max2(LAT_INT, LAT_FADD), max2(LAT_FMUL, LAT_DIV));
    localparam int unsigned DEPTH   = MAX_LAT + WB_GAP + 1;
    localparam int unsigned IDX_W   = $clog2(DEPTH + 1);
    localparam int unsigned CNT_W   = $clog2(LAT_DIV + 1);

    op_class_e        cls;
    logic [IDX_W-1:0] tgt_idx;
    logic             slot_taken;
    logic             div_busy;
    logic             div_block;
    logic             do_accept;

    assign cls = op_class_e'(dec_class);

    wbsr_target #(
        .LAT_INT (LAT_INT),
        .LAT_FADD(LAT_FADD),
        .LAT_FMUL(LAT_FMUL),
        .LAT_DIV (LAT_DIV),
        .WB_GAP  (WB_GAP),
        .IDX_W   (IDX_W)
    ) u_target (
        .op_class(cls),
        .slot_idx(tgt_idx)
    );

    wbsr_slot_ring #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe_idx (tgt_idx),
        .book      (do_accept),
        .probe_busy(slot_taken)
    );

    wbsr_div_guard #(
        .LAT_DIV(LAT_DIV),
        .CNT_W  (CNT_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(do_accept && (cls == OP_DIV)),
        .busy (div_busy)
    );

    // Issue decision
    assign div_block   = (cls == OP_DIV) && div_busy;
    assign issue_stall = dec_valid && (slot_taken || div_block);
    assign do_accept   = dec_valid && !slot_taken && !div_block;
    assign issue_accept = do_accept;

    // Issue tracker: follows whether decode holds a stalled instruction
    iss_state_e iss_q, iss_d;
    op_class_e  held_q;

    always_comb begin
        iss_d = iss_q;
        unique case (iss_q)
            ISS_IDLE: if (issue_stall)  iss_d = ISS_WAIT;
            ISS_WAIT: if (issue_accept) iss_d = ISS_IDLE;
            default:  iss_d = ISS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss_q  <= ISS_IDLE;
            held_q <= OP_INT;
        end else begin
            iss_q  <= iss_d;
            held_q <= cls;
        end
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_q == ISS_WAIT) |-> (dec_valid && cls == held_q));

    // R8
    div_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_accept && cls == OP_DIV) |-> !div_busy);

endmodule

// File: tb/wb_slot_reserve_test.sv
module wb_slot_reserve_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [1:0] dec_class = 2'd0;
    logic       issue_stall;
    logic       issue_accept;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference state built from the requirements
    bit m_slot [0:63];
    int m_div = 0;

    always #10 clk = ~clk;

    wb_slot_reserve uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_valid   (dec_valid),
        .dec_class   (dec_class),
        .issue_stall (issue_stall),
        .issue_accept(issue_accept)
    );

    function automatic int tgt_of(input logic [1:0] c);
        case (c)
            2'd0: return 3;
            2'd1: return 6;
            2'd2: return 9;
            default: return 28;
        endcase
    endfunction

    function automatic bit exp_stall(input logic v, input logic [1:0] c);
        if (!v) return 1'b0;
        return m_slot[tgt_of(c)] || (c == 2'd3 && m_div > 0);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One decode cycle: drive, compare, advance the reference
    task automatic cycle(input logic v, input logic [1:0] c, input string req, output logic acc);
        bit es;
        bit ea;
        dec_valid = v;
        dec_class = c;
        #2;
        es = exp_stall(v, c);
        ea = v && !es;
        check(req, "stall", int'(issue_stall), int'(es));
        check(req, "accept", int'(issue_accept), int'(ea));
        for (int i = 0; i < 63; i++) m_slot[i] = m_slot[i+1];
        m_slot[63] = 1'b0;
        if (ea) m_slot[tgt_of(c) - 1] = 1'b1;
        if (m_div > 0) m_div--;
        if (ea && c == 2'd3) m_div = 24;
        acc = issue_accept;
        @(negedge clk);
    endtask

    // Hold an instruction until accepted; return the stall count
    task automatic issue(input logic [1:0] c, input string req, output int stalls);
        logic acc;
        stalls = 0;
        acc = 1'b0;
        while (!acc) begin
            cycle(1'b1, c, req, acc);
            if (!acc) stalls++;
        end
    endtask

    task automatic idle(input int n);
        logic acc;
        for (int i = 0; i < n; i++) cycle(1'b0, 2'd2, "R2", acc);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int st;
        logic acc;
        logic pend;
        logic [1:0] pc;
        for (int i = 0; i < 64; i++) m_slot[i] = 1'b0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset with no instruction
        check("R1", "stall in reset", int'(issue_stall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first instruction accepted at once
        issue(2'd2, "R1", st);
        check("R1", "first stall count", st, 0);
        idle(40);

        // R6 and R7: mul, int, int, add three cycles after the mul
        issue(2'd2, "R6", st);
        issue(2'd0, "R7", st);
        check("R7", "int after mul stalls", st, 0);
        issue(2'd0, "R7", st);
        check("R7", "second int stalls", st, 0);
        issue(2'd1, "R6", st);
        check("R6", "add stall cycles", st, 1);
        idle(40);

        // R2: an ignored multiply books nothing; add at t+3 goes through
        cycle(1'b0, 2'd2, "R2", acc);
        check("R2", "accept while invalid", int'(acc), 0);
        idle(2);
        issue(2'd1, "R2", st);
        check("R2", "add after unbooked mul", st, 0);
        idle(40);

        // R8, R9: back to back divides, fadd between them
        issue(2'd3, "R8", st);
        issue(2'd1, "R9", st);
        check("R9", "fadd while divider busy", st, 0);
        issue(2'd3, "R8", st);
        check("R8", "second divide stalls", st, 23);
        idle(60);

        // R10: integer 25 cycles after a divide collides on writeback
        issue(2'd3, "R10", st);
        idle(24);
        issue(2'd0, "R10", st);
        check("R10", "int vs divide slot stalls", st, 1);
        idle(60);

        // R3, R4, R5: random stream, stalled instruction held in decode
        pend = 1'b0;
        pc = 2'd0;
        for (int n = 0; n < 5000; n++) begin
            if (!pend) begin
                pend = ($urandom % 4) != 0;
                pc = 2'($urandom % 4);
                if (($urandom % 8) == 0) pc = 2'd3;
            end
            cycle(pend, pc, "R3", acc);
            if (acc) pend = 1'b0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule